// File: doc/BRIEF.md
# Sliding-Offset Pseudo-Random Sequence Correlation Detector

This block decides whether a known pseudo-random bit pattern is buried in a stream of measured samples. Samples arrive on a valid/ready stream. A marker flags the last sample of each clock period. The block averages each period into one compressed value and stores the values in an internal buffer. It then regenerates the expected bit pattern with a replica linear feedback shift register (LFSR) loaded from a given seed.

For every candidate alignment offset in a programmable window, the block computes a mean-removed correlation score between the buffered values and the regenerated pattern. It keeps the best offset and its score. When the sweep ends, it emits a one-cycle done strobe together with a present/absent decision, which compares the peak against a programmable threshold. The correlation length is programmable as a power of two, because longer patterns give a more reliable decision.

A run begins with a `start` pulse while the block is idle. The seed, length exponent, window and threshold are captured on that pulse. The block then takes exactly `2^len_log2 + win_size - 1` periods of samples. The caller keeps that count within the buffer depth, keeps `win_size` at 1 or more, and uses a non-zero seed.

On back-pressure: a sample moves only in a cycle where both `s_valid` and `s_ready` are high. The sender holds `s_data` and `s_last` steady while `s_valid` is high and `s_ready` is low. `s_ready` is high only while a run is collecting samples.

Top module: `seqcorr_detector`

## Requirements
- R1: During and right after reset, `done`, `present`, `best_off`, `peak_score` and `s_ready` are all 0.
- R2: `s_ready` is high only from the cycle after an accepted `start` until the final period of the run has been taken. Samples offered at any other time are not consumed.
- R3: Each period holds exactly 2^SPC_LOG2 samples (4 by default). Its compressed value is floor(sum of those samples / 2^SPC_LOG2).
- R4: The reference bit for position i is bit 0 of the LFSR state after i steps from the seed. One step is `next = (s >> 1) ^ (s[0] ? 16'hB400 : 0)`. The LFSR is reloaded from the seed for every offset.
- R5: For offset o, with L = 2^len_log2, v_i = compressed value o+i, and b_i = +1 for reference bit 1 and -1 for reference bit 0, the score is L*sum(v_i*b_i) - sum(v_i)*sum(b_i). This is L times the mean-removed correlation, computed exactly.
- R6: Offsets 0 to win_size-1 are all scored. `best_off` is the offset with the highest score. On a tie, the lowest offset wins. `peak_score` is that score.
- R7: `present` is 1 exactly when `peak_score` is strictly greater than the signed `threshold` captured at start.
- R8: `done` is high for exactly one cycle per run. `present`, `best_off` and `peak_score` change only in a cycle where `done` is high, and they hold until the next run's done.
- R9: A `start` pulse that arrives while a run is in progress is ignored and has no effect on that run's results.
- R10: The correlation length is 2^len_log2 compressed values, and the block takes 2^len_log2 + win_size - 1 periods per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle; captures the configuration inputs |
| seed | input | LFSR_W | Replica LFSR seed (non-zero) |
| len_log2 | input | LENL_W | Correlation length exponent |
| win_size | input | WIN_W | Number of offsets to score (1 or more) |
| threshold | input | SCORE_W | Signed decision threshold |
| s_valid | input | 1 | Sample valid |
| s_ready | output | 1 | Sample accepted when high together with s_valid |
| s_data | input | SAMPLE_W | Unsigned sample |
| s_last | input | 1 | Marks the last sample of a clock period |
| done | output | 1 | One-cycle strobe: results updated |
| present | output | 1 | Peak exceeded threshold |
| best_off | output | ADDR_W | Offset of the peak |
| peak_score | output | SCORE_W | Signed peak score |

## Verification
A wrong accumulator, a wrong buffer entry or a wrong LFSR state never shows at the ports until the done strobe. It then shows as a `peak_score` that differs from the bench's exact integer model, usually along with a different `best_off`. This happens within (L+1)*win_size+1 cycles of the last accepted sample. Errors in the capture count show sooner: `s_ready` stays high or drops early, so the feed either stalls or leaves samples unconsumed. Constant inputs, which give all-zero scores, show whether the tie rule and the strict threshold compare are right. Noise-only and embedded-pattern runs confirm the arithmetic on varied data.

// File: rtl/seqcorr_pkg.sv
package seqcorr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPT,
    ST_SWEEP,
    ST_EVAL,
    ST_DONE
  } seqcorr_state_e;
endpackage

// File: rtl/seqcorr_compress.sv
// Sums the samples of one period and emits the average on the closing marker.
module seqcorr_compress #(
  parameter int SAMPLE_W = 8,
  parameter int SPC_LOG2 = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                in_fire,
  input  logic                in_last,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_value
);
  localparam int ACC_W = SAMPLE_W + SPC_LOG2;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  assign sum       = acc_q + ACC_W'(in_data);
  assign out_valid = in_fire & in_last;
  assign out_value = SAMPLE_W'(sum >> SPC_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n)       acc_q <= '0;
    else if (clr)     acc_q <= '0;
    else if (in_fire) acc_q <= in_last ? '0 : sum;
  end
endmodule

// File: rtl/seqcorr_lfsr.sv
// Galois replica generator; output bit is bit 0 of the current state.
module seqcorr_lfsr #(
  parameter int              LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [LFSR_W-1:0] seed,
  output logic              bit_out
);
  logic [LFSR_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    st_q <= '0;
    else if (load) st_q <= seed;
    else if (step) st_q <= {1'b0, st_q[LFSR_W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  assign bit_out = st_q[0];
endmodule

// File: rtl/seqcorr_mac.sv
// Running sums for one offset and the exact scaled mean-removed score.
module seqcorr_mac #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 15,
  parameter int SCORE_W  = 30,
  parameter int LENL_W   = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      en,
  input  logic [SAMPLE_W-1:0]       value,
  input  logic                      ref_bit,
  input  logic [LENL_W-1:0]         len_log2,
  output logic signed [SCORE_W-1:0] score
);
  localparam logic signed [ACC_W-1:0] ONE = ACC_W'(1);

  logic signed [ACC_W-1:0] sv_q, sb_q, svb_q;
  logic signed [ACC_W-1:0] v_ext;

  assign v_ext = signed'(ACC_W'(value));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sv_q  <= '0;
      sb_q  <= '0;
      svb_q <= '0;
    end else if (en) begin
      sv_q  <= sv_q + v_ext;
      sb_q  <= ref_bit ? sb_q + ONE : sb_q - ONE;
      svb_q <= ref_bit ? svb_q + v_ext : svb_q - v_ext;
    end
  end

  assign score = (SCORE_W'(svb_q) <<< len_log2) - SCORE_W'(sv_q) * SCORE_W'(sb_q);
endmodule

// File: rtl/seqcorr_detector.sv
module seqcorr_detector
  import seqcorr_pkg::*;
#(
  parameter int              SAMPLE_W     = 8,
  parameter int              SPC_LOG2     = 2,
  parameter int              DEPTH        = 64,
  parameter int              LFSR_W       = 16,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 16'hB400,
  parameter int              LEN_LOG2_MAX = 5,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int WIN_W   = ADDR_W + 1,
  localparam int LENL_W  = $clog2(LEN_LOG2_MAX + 1),
  localparam int ACC_W   = SAMPLE_W + LEN_LOG2_MAX + 2,
  localparam int SCORE_W = 2 * ACC_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [LFSR_W-1:0]         seed,
  input  logic [LENL_W-1:0]         len_log2,
  input  logic [WIN_W-1:0]          win_size,
  input  logic signed [SCORE_W-1:0] threshold,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [SAMPLE_W-1:0]       s_data,
  input  logic                      s_last,
  output logic                      done,
  output logic                      present,
  output logic [ADDR_W-1:0]         best_off,
  output logic signed [SCORE_W-1:0] peak_score
);
  localparam int NEED_W = ADDR_W + 2;
  localparam int IDX_W  = LEN_LOG2_MAX + 1;

  seqcorr_state_e state_q;
  logic [LFSR_W-1:0]         seed_q;
  logic [LENL_W-1:0]         len_q;
  logic [WIN_W-1:0]          win_q;
  logic signed [SCORE_W-1:0] thr_q;
  logic [NEED_W-1:0]         wr_cnt_q;
  logic [WIN_W-1:0]          off_q;
  logic [IDX_W-1:0]          idx_q;
  logic signed [SCORE_W-1:0] best_q;
  logic [ADDR_W-1:0]         best_off_q;
  logic [SAMPLE_W-1:0]       mem [DEPTH];

  logic [NEED_W-1:0]         need;
  logic [IDX_W-1:0]          last_idx;
  logic [NEED_W-1:0]         rd_addr;
  logic                      in_fire, comp_valid, ref_bit;
  logic [SAMPLE_W-1:0]       comp_value;
  logic                      lfsr_load, mac_clr, mac_en;
  logic signed [SCORE_W-1:0] score;
  logic                      capt_end;

  assign need     = (NEED_W'(1) << len_q) + NEED_W'(win_q) - NEED_W'(1);
  assign last_idx = (IDX_W'(1) << len_q) - IDX_W'(1);
  assign rd_addr  = NEED_W'(off_q) + NEED_W'(idx_q);
  assign s_ready  = (state_q == ST_CAPT);
  assign in_fire  = s_valid & s_ready;
  assign capt_end = comp_valid && (wr_cnt_q + NEED_W'(1) == need);

  assign lfsr_load = capt_end || (state_q == ST_EVAL);
  assign mac_clr   = ((state_q == ST_IDLE) && start) || (state_q == ST_EVAL);
  assign mac_en    = (state_q == ST_SWEEP);

  seqcorr_compress #(.SAMPLE_W(SAMPLE_W), .SPC_LOG2(SPC_LOG2)) u_comp (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr && state_q == ST_IDLE),
    .in_fire(in_fire), .in_last(s_last), .in_data(s_data),
    .out_valid(comp_valid), .out_value(comp_value)
  );

  seqcorr_lfsr #(.LFSR_W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(lfsr_load), .step(mac_en),
    .seed(seed_q), .bit_out(ref_bit)
  );

  seqcorr_mac #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .SCORE_W(SCORE_W), .LENL_W(LENL_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(mac_clr), .en(mac_en),
    .value(mem[rd_addr[ADDR_W-1:0]]), .ref_bit(ref_bit),
    .len_log2(len_q), .score(score)
  );

  always_ff @(posedge clk) begin
    if (comp_valid) mem[wr_cnt_q[ADDR_W-1:0]] <= comp_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seed_q     <= '0;
      len_q      <= '0;
      win_q      <= '0;
      thr_q      <= '0;
      wr_cnt_q   <= '0;
      off_q      <= '0;
      idx_q      <= '0;
      best_q     <= '0;
      best_off_q <= '0;
      done       <= 1'b0;
      present    <= 1'b0;
      best_off   <= '0;
      peak_score <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          seed_q   <= seed;
          len_q    <= len_log2;
          win_q    <= win_size;
          thr_q    <= threshold;
          wr_cnt_q <= '0;
          state_q  <= ST_CAPT;
        end
        ST_CAPT: if (comp_valid) begin
          wr_cnt_q <= wr_cnt_q + NEED_W'(1);
          if (capt_end) begin
            off_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_SWEEP;
          end
        end
        ST_SWEEP: begin
          if (idx_q == last_idx) state_q <= ST_EVAL;
          else                   idx_q   <= idx_q + IDX_W'(1);
        end
        ST_EVAL: begin
          if (off_q == '0 || score > best_q) begin
            best_q     <= score;
            best_off_q <= off_q[ADDR_W-1:0];
          end
          idx_q <= '0;
          if (off_q == win_q - WIN_W'(1)) state_q <= ST_DONE;
          else begin
            off_q   <= off_q + WIN_W'(1);
            state_q <= ST_SWEEP;
          end
        end
        ST_DONE: begin
          best_off   <= best_off_q;
          peak_score <= best_q;
          present    <= best_q > thr_q;
          done       <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqcorr_detector_chk.sv
module seqcorr_detector_chk #(
  parameter int ADDR_W  = 6,
  parameter int WIN_W   = 7,
  parameter int SCORE_W = 30
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      s_ready,
  input logic                      done,
  input logic                      present,
  input logic [ADDR_W-1:0]         best_off,
  input logic signed [SCORE_W-1:0] peak_score,
  input logic signed [SCORE_W-1:0] thr_q,
  input logic [WIN_W-1:0]          win_q
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(present) && $stable(best_off) && $stable(peak_score)));

  // R7
  present_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (present == (peak_score > thr_q)));

  // R6
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, best_off} < win_q));

  // R2
  ready_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(start));

  // R2
  ready_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !s_ready);
endmodule

bind seqcorr_detector seqcorr_detector_chk #(
  .ADDR_W(ADDR_W), .WIN_W(WIN_W), .SCORE_W(SCORE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_ready(s_ready),
  .done(done), .present(present), .best_off(best_off),
  .peak_score(peak_score), .thr_q(thr_q), .win_q(win_q)
);

// File: tb/tb_seqcorr_detector.sv
module tb_seqcorr_detector;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [15:0]        seed = 16'h1;
  logic [2:0]         len_log2 = '0;
  logic [6:0]         win_size = 7'd1;
  logic signed [29:0] threshold = '0;
  logic               s_valid = 1'b0;
  logic               s_ready;
  logic [7:0]         s_data = '0;
  logic               s_last = 1'b0;
  logic               done, present;
  logic [5:0]         best_off;
  logic signed [29:0] peak_score;

  int checks = 0;
  int errors = 0;
  int smp [0:255];
  int comp [0:63];
  int rb [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  seqcorr_detector dut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed), .len_log2(len_log2),
    .win_size(win_size), .threshold(threshold), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .done(done), .present(present),
    .best_off(best_off), .peak_score(peak_score)
  );

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R4 reference step
  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0);
  endfunction

  // R5/R6 model over comp[]
  task automatic model(logic [15:0] sd, int lenl, int win,
                       output int e_off, output longint e_peak);
    int L = 1 << lenl;
    e_off = 0; e_peak = 0;
    for (int o = 0; o < win; o++) begin
      logic [15:0] s = sd;
      longint sv = 0, sb = 0, svb = 0, sc;
      for (int i = 0; i < L; i++) begin
        sv += comp[o+i];
        if (s[0]) begin sb += 1; svb += comp[o+i]; end
        else      begin sb -= 1; svb -= comp[o+i]; end
        s = lfsr_next(s);
      end
      sc = svb * L - sv * sb;
      if (o == 0 || sc > e_peak) begin e_peak = sc; e_off = o; end
    end
  endtask

  task automatic run_case(string name, logic [15:0] sd, int lenl, int win, int thr,
                          int eoff, int amp, int noise, int gap_pct, bit busy_start);
    int L = 1 << lenl;
    int need = L + win - 1;
    int n = need * 4;
    int e_off, i, guard, hold_off;
    longint e_peak, hold_pk;
    logic [15:0] s = sd;
    bit hold_pr;
    for (int k = 0; k < L; k++) begin rb[k] = s[0]; s = lfsr_next(s); end
    for (int k = 0; k < need; k++) begin
      int pv = 60, sum = 0;
      if (k >= eoff && k < eoff + L && rb[k-eoff] != 0) pv += amp;
      for (int j = 0; j < 4; j++) begin
        int x = pv + int'($urandom_range(0, noise));
        if (x > 255) x = 255;
        smp[k*4+j] = x;
        sum += x;
      end
      comp[k] = sum >> 2; // R3
    end
    model(sd, lenl, win, e_off, e_peak);

    @(negedge clk);
    s_valid = 1'b1; s_data = 8'(smp[0]); s_last = 1'b0;
    check(s_ready == 1'b0, "R2", {name, " ready while idle"}, s_ready, 0);
    start = 1'b1; seed = sd; len_log2 = 3'(lenl); win_size = 7'(win); threshold = 30'(thr);
    @(negedge clk);
    start = 1'b0;
    i = 0; guard = 0;
    while (i < n && guard < 5000) begin
      guard++;
      if (gap_pct > 0 && int'($urandom_range(0, 99)) < gap_pct) s_valid = 1'b0;
      else begin
        s_valid = 1'b1; s_data = 8'(smp[i]); s_last = (i % 4 == 3);
        if (s_ready) i++;
      end
      @(negedge clk);
    end
    check(i == n, "R10", {name, " samples taken"}, i, n);
    s_valid = 1'b1; s_data = 8'hFF; s_last = 1'b1;
    check(s_ready == 1'b0, "R2", {name, " ready after capture"}, s_ready, 0);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
    if (busy_start) begin
      repeat (3) @(negedge clk);
      start = 1'b1; seed = 16'h0001; len_log2 = 3'd1; win_size = 7'd1; threshold = 30'sd999999;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin guard++; @(negedge clk); end
    check(done == 1'b1, "R8", {name, " done seen (watchdog)"}, done, 1);
    check(best_off == 6'(e_off), "R6", {name, " best_off"}, best_off, e_off);
    check(longint'(peak_score) == e_peak, "R5", {name, " peak_score"}, peak_score, e_peak);
    check(present == (e_peak > thr), "R7", {name, " present"}, present, (e_peak > thr));
    hold_pr = present; hold_off = best_off; hold_pk = peak_score;
    @(negedge clk);
    check(done == 1'b0, "R8", {name, " done one cycle"}, done, 0);
    repeat (4) @(negedge clk);
    check(present == hold_pr && best_off == 6'(hold_off) && longint'(peak_score) == hold_pk,
          "R8", {name, " results held"}, peak_score, hold_pk);
    check(s_ready == 1'b0, "R9", {name, " no restart from busy start"}, s_ready, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 0, "R1", "done in reset", done, 0);
    check(present == 0, "R1", "present in reset", present, 0);
    check(best_off == 0, "R1", "best_off in reset", best_off, 0);
    check(peak_score == 0, "R1", "peak in reset", peak_score, 0);
    check(s_ready == 0, "R1", "s_ready in reset", s_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_case("embedded",   16'hACE1, 5, 16, 8000,   9, 40, 30, 0,  1'b0);
    run_case("noise_only", 16'h5A5A, 5, 16, 100000, 99, 0, 60, 20, 1'b0);
    run_case("flat_tie",   16'h1234, 4, 8,  0,      99, 0, 0,  0,  1'b0);
    run_case("flat_neg",   16'h0F0F, 4, 8,  -1,     99, 0, 0,  30, 1'b0);
    run_case("short_busy", 16'hBEEF, 2, 4,  50,     2,  80, 20, 10, 1'b1);
    run_case("round_mix",  16'h7001, 3, 20, 300,    11, 25, 3,  0,  1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule